// File: doc/BRIEF.md
# Receive FIFO Character Time-Out Detector

This block watches a UART receive FIFO and raises a flag for the interrupt logic when characters have been waiting without activity for four character times. It contains its own divisor-driven sample-tick generator, which produces the 16x oversampling tick from the system clock. The same tick is also brought out so that a receiver can share it.

The length of the time-out follows the current line format. The block adds up the start bit, the data bits, an optional parity bit and a stop period of one, one and a half or two bits, all counted in 16x ticks. Four of those character lengths make the limit, so a window that contains a half stop bit is still exact. The timer runs only while the FIFO holds data. Each new character restarts it. A read of the receive holding register restarts it and clears the flag. An empty FIFO clears both the timer and the flag.

Top module: `rx_fifo_timeout`

## Requirements
- R1: The divisor D is loaded one byte per write: `div_lo_we` writes bits 7:0 and `div_hi_we` writes bits 15:8 from `div_wdata`. With D nonzero, `rx_tick16` is high for one clock in every D clocks.
- R2: While D is 0, `rx_tick16` never goes high.
- R3: A write to either divisor byte restarts the divider. The first tick then appears in the D-th clock cycle after the write edge.
- R4: The time-out limit in ticks is 4 × (16 × (1 + W + P) + S). `word_len_sel` values 0, 1, 2, 3 give W = 5, 6, 7, 8 data bits. P is 1 when `parity_en` is high and 0 otherwise. `stop_sel` 00 gives S = 16, 01 gives S = 24, and 10 or 11 gives S = 32.
- R5: After a restart, `rx_timeout` rises on the clock edge that consumes the limit-th tick, and not on any edge before it.
- R6: A `rx_char_pulse` while the FIFO is non-empty restarts the count. It does not clear a flag that is already set.
- R7: A `rhr_read_pulse` clears `rx_timeout` on the next edge and restarts the count.
- R8: While `fifo_nonempty` is low, the count and the flag are held at zero. Counting resumes from zero in the first non-empty cycle.
- R9: Once set, `rx_timeout` stays high as long as the FIFO stays non-empty and no read occurs, even if further ticks arrive.
- R10: After reset, `rx_timeout` is low, D is 0 and no tick is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the divider and the timer |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_lo_we | input | 1 | Write strobe for the low divisor byte |
| div_hi_we | input | 1 | Write strobe for the high divisor byte |
| div_wdata | input | 8 | Divisor byte to be written |
| word_len_sel | input | 2 | Data bits per character, 0..3 meaning 5..8 |
| parity_en | input | 1 | Frame carries a parity bit |
| stop_sel | input | 2 | Stop length: 00 one bit, 01 one and a half, 1x two |
| fifo_nonempty | input | 1 | Receive FIFO holds at least one character |
| rx_char_pulse | input | 1 | One-cycle pulse per received character |
| rhr_read_pulse | input | 1 | One-cycle pulse per read of the receive holding register |
| rx_tick16 | output | 1 | 16x sample tick from the divider |
| rx_timeout | output | 1 | Character time-out indication |

## Verification
All 24 combinations of word length, parity and stop selection are run with a divisor of 1, and one combination is run with a divisor of 3. For each run the bench compares the exact edge on which the flag rises against the limit it computes from the formula. A wrong term for the data bits, the parity bit or the half stop bit therefore shows up as an early or late rise in one identifiable configuration.

The divider is checked in four situations:
- a divisor of 0;
- a short divisor of 3;
- a divisor of 258, which has both bytes nonzero and so catches a byte swap;
- the first-tick delay after a write.

Separate sequences interrupt a partial count with a character, a read or an empty FIFO. These show apart restart-only, restart-and-clear and hold-at-zero behaviour, and a flag that is held against one that is re-armed.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

    // Encoding of the stop-period selection input.
    typedef enum logic [1:0] {
        STOP_ONE      = 2'b00,
        STOP_ONE_HALF = 2'b01,
        STOP_TWO      = 2'b10,
        STOP_TWO_ALT  = 2'b11
    } stop_sel_e;

    // Smallest data width selectable; the 2-bit select adds 0..3 to it.
    localparam int unsigned DATA_BITS_MIN = 5;
    localparam int unsigned DATA_BITS_MAX = DATA_BITS_MIN + 3;

    // Stop period length in oversampling ticks.
    function automatic int unsigned stop_ticks(stop_sel_e sel, int unsigned ovs);
        case (sel)
            STOP_ONE:      return ovs;
            STOP_ONE_HALF: return ovs + ovs / 2;
            default:       return 2 * ovs;
        endcase
    endfunction

    // Largest possible time-out limit, used to size the timer.
    function automatic int unsigned max_limit(int unsigned ovs, int unsigned chars);
        return chars * (ovs * (1 + DATA_BITS_MAX + 1) + 2 * ovs);
    endfunction

endpackage

// File: rtl/rxto_baud_gen.sv
module rxto_baud_gen #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_we_i,
    input  logic             hi_we_i,
    input  logic [DIV_W/2-1:0] wdata_i,
    output logic             tick_o
);
    localparam int unsigned BYTE_W = DIV_W / 2;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
    } baud_st_t;

    baud_st_t st_d, st_q;
    logic     any_we;
    logic     tick_c;

    assign any_we = lo_we_i | hi_we_i;

    always_comb begin
        tick_c = (st_q.div != '0) && (st_q.cnt >= (st_q.div - DIV_W'(1)));
        st_d   = st_q;
        if (lo_we_i) st_d.div[BYTE_W-1:0]     = wdata_i;
        if (hi_we_i) st_d.div[DIV_W-1:BYTE_W] = wdata_i;
        if (any_we) begin
            st_d.cnt = '0;
        end else if (st_q.div == '0) begin
            st_d.cnt = '0;
        end else if (tick_c) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = tick_c;

    // R3: right after a write the divider starts over.
    p_write_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        any_we |=> (tick_o == (st_q.div == DIV_W'(1))));

    // R1: with a divisor above one, ticks are never back to back.
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && st_q.div > DIV_W'(1) && !any_we) |=> !tick_o);

endmodule

// File: rtl/rxto_frame_calc.sv
module rxto_frame_calc
    import rxto_pkg::*;
#(
    parameter int unsigned OVS      = 16,
    parameter int unsigned TO_CHARS = 4,
    parameter int unsigned LIM_W    = 10
) (
    input  logic [1:0]       word_len_i,
    input  logic             parity_i,
    input  logic [1:0]       stop_i,
    output logic [LIM_W-1:0] limit_o
);
    int unsigned bits_c;
    int unsigned char_c;

    always_comb begin
        bits_c  = 1 + DATA_BITS_MIN + int'(word_len_i) + (parity_i ? 1 : 0);
        char_c  = bits_c * OVS + stop_ticks(stop_sel_e'(stop_i), OVS);
        limit_o = LIM_W'(TO_CHARS * char_c);
    end

endmodule

// File: rtl/rxto_timer.sv
module rxto_timer #(
    parameter int unsigned LIM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [LIM_W-1:0] limit_i,
    input  logic             nonempty_i,
    input  logic             char_i,
    input  logic             read_i,
    output logic             flag_o
);
    typedef struct packed {
        logic [LIM_W-1:0] cnt;
        logic             flag;
    } tmr_st_t;

    tmr_st_t          st_d, st_q;
    logic [LIM_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc = st_q.cnt + LIM_W'(1);
        st_d    = st_q;
        if (!nonempty_i) begin
            st_d = '0;
        end else if (read_i) begin
            st_d.cnt  = '0;
            st_d.flag = 1'b0;
        end else if (char_i) begin
            st_d.cnt = '0;
        end else if (tick_i && !st_q.flag) begin
            if (cnt_inc >= limit_i) begin
                st_d.flag = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R8: an empty FIFO leaves no flag behind.
    p_empty_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !nonempty_i |=> !flag_o);

    // R7: a read always drops the flag.
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        read_i |=> !flag_o);

    // R9: a set flag persists while data remains unread.
    p_flag_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && nonempty_i && !read_i) |=> flag_o);

    // R5: the flag can only rise on an edge that consumed a tick.
    p_rise_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(tick_i));

    // R6: a new character never changes the flag.
    p_char_keeps_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (char_i && nonempty_i && !read_i) |=> (flag_o == $past(flag_o)));

endmodule

// File: rtl/rx_fifo_timeout.sv
module rx_fifo_timeout
    import rxto_pkg::*;
#(
    parameter int unsigned DIV_W    = 16,
    parameter int unsigned OVS      = 16,
    parameter int unsigned TO_CHARS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               div_lo_we,
    input  logic               div_hi_we,
    input  logic [DIV_W/2-1:0] div_wdata,
    input  logic [1:0]         word_len_sel,
    input  logic               parity_en,
    input  logic [1:0]         stop_sel,
    input  logic               fifo_nonempty,
    input  logic               rx_char_pulse,
    input  logic               rhr_read_pulse,
    output logic               rx_tick16,
    output logic               rx_timeout
);
    localparam int unsigned LIM_W = $clog2(max_limit(OVS, TO_CHARS) + 1);

    logic             tick_w;
    logic [LIM_W-1:0] limit_w;

    rxto_baud_gen #(
        .DIV_W (DIV_W)
    ) baud_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_we_i (div_lo_we),
        .hi_we_i (div_hi_we),
        .wdata_i (div_wdata),
        .tick_o  (tick_w)
    );

    rxto_frame_calc #(
        .OVS      (OVS),
        .TO_CHARS (TO_CHARS),
        .LIM_W    (LIM_W)
    ) frame_i (
        .word_len_i (word_len_sel),
        .parity_i   (parity_en),
        .stop_i     (stop_sel),
        .limit_o    (limit_w)
    );

    rxto_timer #(
        .LIM_W (LIM_W)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_w),
        .limit_i    (limit_w),
        .nonempty_i (fifo_nonempty),
        .char_i     (rx_char_pulse),
        .read_i     (rhr_read_pulse),
        .flag_o     (rx_timeout)
    );

    assign rx_tick16 = tick_w;

endmodule

// File: tb/rx_fifo_timeout_tb.sv
module rx_fifo_timeout_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       div_lo_we, div_hi_we;
    logic [7:0] div_wdata;
    logic [1:0] word_len_sel;
    logic       parity_en;
    logic [1:0] stop_sel;
    logic       fifo_nonempty, rx_char_pulse, rhr_read_pulse;
    logic       rx_tick16, rx_timeout;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    rx_fifo_timeout dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .div_lo_we      (div_lo_we),
        .div_hi_we      (div_hi_we),
        .div_wdata      (div_wdata),
        .word_len_sel   (word_len_sel),
        .parity_en      (parity_en),
        .stop_sel       (stop_sel),
        .fifo_nonempty  (fifo_nonempty),
        .rx_char_pulse  (rx_char_pulse),
        .rhr_read_pulse (rhr_read_pulse),
        .rx_tick16      (rx_tick16),
        .rx_timeout     (rx_timeout)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_limit(int wl, int par, int st);
        int s;
        s = (st == 0) ? 16 : (st == 1) ? 24 : 32;
        return 4 * (16 * (1 + 5 + wl + par) + s);
    endfunction

    // Writes both divisor bytes; returns at the negedge after the high-byte write edge.
    task automatic write_div(input int value);
        @(negedge clk);
        div_lo_we = 1'b1; div_wdata = value[7:0];
        @(negedge clk);
        div_lo_we = 1'b0; div_hi_we = 1'b1; div_wdata = value[15:8];
        @(negedge clk);
        div_hi_we = 1'b0;
    endtask

    // Number of negedges from now until the first tick (0 if ticking now).
    task automatic cycles_to_tick(input int bound, output int n);
        n = -1;
        for (int i = 0; i <= bound; i++) begin
            if (rx_tick16) begin n = i; break; end
            @(negedge clk);
        end
    endtask

    // Called at a negedge where inputs already request counting. Follows ticks and
    // compares the flag against the computed limit on every cycle.
    task automatic run_count(input int limit, input int div, input string tag);
        int seen = 0;
        int bad_at = -1;
        int act_at = -1;
        int max_it = (limit + 3) * div + 20;
        for (int it = 0; it < max_it && seen < limit + 3; it++) begin
            if (rx_timeout && act_at < 0) act_at = seen;
            if (rx_timeout != (seen >= limit) && bad_at < 0) bad_at = seen;
            if (rx_tick16) seen++;
            @(negedge clk);
        end
        check(bad_at < 0 && seen >= limit + 3, tag, act_at, limit);
    endtask

    task automatic pulse_char();
        rx_char_pulse = 1'b1;
        @(negedge clk);
        rx_char_pulse = 1'b0;
    endtask

    task automatic pulse_read();
        rhr_read_pulse = 1'b1;
        @(negedge clk);
        rhr_read_pulse = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        int n;
        int t;
        int lim;
        rst_n = 1'b0;
        div_lo_we = 0; div_hi_we = 0; div_wdata = 0;
        word_len_sel = 0; parity_en = 0; stop_sel = 0;
        fifo_nonempty = 0; rx_char_pulse = 0; rhr_read_pulse = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check(rx_timeout == 1'b0, "R10 flag after reset", rx_timeout, 0);
        check(rx_tick16 == 1'b0, "R10 tick after reset", rx_tick16, 0);

        // R2: divisor 0 after reset gives no ticks, even with data waiting
        fifo_nonempty = 1'b1;
        t = 0;
        for (int i = 0; i < 60; i++) begin
            if (rx_tick16) t++;
            @(negedge clk);
        end
        check(t == 0, "R2 ticks with zero divisor", t, 0);
        check(rx_timeout == 1'b0, "R2 no time-out without ticks", rx_timeout, 0);
        fifo_nonempty = 1'b0;

        // R3 + R1: divisor 3
        write_div(3);
        cycles_to_tick(20, n);
        check(n == 2, "R3 first tick after write (D=3)", n + 1, 3);
        for (int g = 0; g < 3; g++) begin
            @(negedge clk);
            cycles_to_tick(20, n);
            check(n == 2, "R1 tick period D=3", n + 1, 3);
        end

        // R1 + R3: divisor 258 uses both bytes
        write_div(258);
        cycles_to_tick(400, n);
        check(n == 257, "R3 first tick after write (D=258)", n + 1, 258);
        @(negedge clk);
        cycles_to_tick(400, n);
        check(n == 257, "R1 tick period D=258", n + 1, 258);

        // R3: rewriting the same high byte mid-period restarts the divider
        repeat (100) @(negedge clk);
        div_hi_we = 1'b1; div_wdata = 8'h01;
        @(negedge clk);
        div_hi_we = 1'b0;
        cycles_to_tick(400, n);
        check(n == 257, "R3 restart on single byte write", n + 1, 258);

        // R2: back to zero stops the ticks
        write_div(0);
        t = 0;
        for (int i = 0; i < 300; i++) begin
            if (rx_tick16) t++;
            @(negedge clk);
        end
        check(t == 0, "R2 ticks after divisor cleared", t, 0);

        // R4 R5 R8: full sweep of the line format with a tick every clock
        write_div(1);
        for (int wl = 0; wl < 4; wl++) begin
            for (int par = 0; par < 2; par++) begin
                for (int st = 0; st < 3; st++) begin
                    fifo_nonempty = 1'b0;
                    word_len_sel = 2'(wl); parity_en = par[0]; stop_sel = 2'(st);
                    @(negedge clk);
                    fifo_nonempty = 1'b1;
                    run_count(exp_limit(wl, par, st), 1, "R4 R5 limit sweep");
                    fifo_nonempty = 1'b0;
                    @(negedge clk);
                    check(rx_timeout == 1'b0, "R8 empty clears flag", rx_timeout, 0);
                end
            end
        end

        // R4: stop select 11 behaves as two stop bits
        word_len_sel = 2'd1; parity_en = 1'b0; stop_sel = 2'b11;
        @(negedge clk);
        fifo_nonempty = 1'b1;
        run_count(exp_limit(1, 0, 2), 1, "R4 stop select 11");
        fifo_nonempty = 1'b0;
        @(negedge clk);

        // R6 R9 R7: eight data bits, parity, two stop bits
        word_len_sel = 2'd3; parity_en = 1'b1; stop_sel = 2'b10;
        lim = exp_limit(3, 1, 2);
        fifo_nonempty = 1'b1;
        repeat (300) @(negedge clk);
        pulse_char();
        run_count(lim, 1, "R6 char restarts count");
        pulse_char();
        check(rx_timeout == 1'b1, "R6 char keeps flag", rx_timeout, 1);
        repeat (100) @(negedge clk);
        check(rx_timeout == 1'b1, "R9 flag held", rx_timeout, 1);
        pulse_read();
        check(rx_timeout == 1'b0, "R7 read clears flag", rx_timeout, 0);
        run_count(lim, 1, "R7 count after read");

        // R7: read partway restarts; read and char together also clear
        pulse_read();
        repeat (500) @(negedge clk);
        rhr_read_pulse = 1'b1; rx_char_pulse = 1'b1;
        @(negedge clk);
        rhr_read_pulse = 1'b0; rx_char_pulse = 1'b0;
        run_count(lim, 1, "R7 partial count restarted by read");

        // R8: empty partway discards progress
        pulse_read();
        repeat (500) @(negedge clk);
        fifo_nonempty = 1'b0;
        repeat (5) @(negedge clk);
        check(rx_timeout == 1'b0, "R8 flag low while empty", rx_timeout, 0);
        fifo_nonempty = 1'b1;
        run_count(lim, 1, "R8 count from zero after empty");

        // R5: slower tick (divisor 3), shortest frame
        fifo_nonempty = 1'b0;
        write_div(3);
        word_len_sel = 2'd0; parity_en = 1'b0; stop_sel = 2'b00;
        @(negedge clk);
        fifo_nonempty = 1'b1;
        run_count(exp_limit(0, 0, 0), 3, "R5 limit with D=3");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule